// File: doc/BRIEF.md
# Fused Sign-Magnitude Multiply-Accumulate

This block multiplies two signed operands held in sign-magnitude form and adds the product into a running 64-bit two's-complement total in a single clock cycle. The magnitude bits are ANDed into one row per multiplier bit. The running total joins those rows as one more row of the carry-save compression tree. A carry-lookahead adder then resolves the last two rows. No separate accumulator adder follows the multiplier, so one accumulate step has the logic depth of one plain multiply.

Sign logic takes the product sign as the XOR of the operand signs. A negative product enters the tree as inverted rows plus one constant correction row, which turns the tree's output into the two's-complement difference. A step is accepted when both `in_valid` and `acc_en` are high. A step that also carries `acc_clr` drops the running total and loads the bare product. The total wraps modulo 2^64, and a signed overflow is remembered until the next clearing step.

A three-state controller tracks the total:
- `ST_EMPTY`: after reset, before any accepted step.
- `ST_LIVE`: the total holds valid data and no overflow has been seen.
- `ST_WRAPPED`: an overflow has been seen.

The transitions are:
- `ST_EMPTY` to `ST_LIVE` on any accepted step.
- `ST_LIVE` to `ST_WRAPPED` on an accepted step that overflows.
- `ST_WRAPPED` to `ST_LIVE` on an accepted step with `acc_clr`.
- Every other case keeps the current state.

Top module: `smfm_mac_top`

## Requirements
- R1: While reset is asserted and after it is released, before any accepted step, `acc_q` is 0, `out_valid` is 0 and `ovf_sticky` is 0.
- R2: An accepted step (`in_valid` and `acc_en` both 1) with `acc_clr` 0 makes `acc_q` equal to the old total plus the signed product, modulo 2^64, on the next clock edge.
- R3: An accepted step with `acc_clr` 1 loads `acc_q` with the signed product alone and clears `ovf_sticky`.
- R4: When `in_valid` or `acc_en` is 0, `acc_q` and `ovf_sticky` keep their values and `out_valid` is 0 after the next edge. `acc_clr` and the operands have no effect in such a cycle.
- R5: An operand with zero magnitude gives a zero product whatever its sign bit, so an accumulate step with that operand leaves `acc_q` unchanged.
- R6: An accumulate step whose operands have the same sign as the old total, but whose result has the other sign, sets `ovf_sticky` and stores the wrapped result. `ovf_sticky` then stays 1 until an accepted clearing step.
- R7: Each operand carries its sign in bit 31 (1 = negative) and its magnitude in bits 30:0. The product is negative when exactly one sign bit is set.
- R8: Steps may be accepted on consecutive cycles. Each one updates `acc_q` and raises `out_valid` exactly one edge after its cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands present this cycle |
| acc_en | input | 1 | Allows the total to update |
| acc_clr | input | 1 | Start a new total from the current product |
| op_a | input | 32 | Sign-magnitude operand A |
| op_b | input | 32 | Sign-magnitude operand B |
| acc_q | output | 64 | Registered two's-complement total |
| out_valid | output | 1 | One-cycle pulse after each accepted step |
| ovf_sticky | output | 1 | Signed overflow seen since the last clear |

## Verification
The total feeds back into its own tree, so any single wrong bit in a row, a compressor or the lookahead carries persists in `acc_q` from then on. The scoreboard sees it on the edge right after the faulty step and on every later comparison. A wrong sign decision shows the same way, but only for products whose magnitude is nonzero. A controller fault shows as `ovf_sticky` changing on a hold cycle, or failing to drop on a clearing step, on the very next edge.

// File: rtl/smfm_pkg.sv
`timescale 1ns/1ps
package smfm_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_LIVE    = 2'd1,
        ST_WRAPPED = 2'd2
    } mac_state_t;

    // Largest height of the staged sequence 2,3,4,6,9,... that is below r.
    function automatic int dadda_below(input int r);
        int d;
        d = 2;
        while (((d * 3) / 2) < r) d = (d * 3) / 2;
        return d;
    endfunction

    function automatic int rows_after(input int r0, input int lvl);
        int r;
        r = r0;
        for (int i = 0; i < lvl; i++) if (r > 2) r = dadda_below(r);
        return r;
    endfunction

    function automatic int tree_levels(input int r0);
        int r;
        int n;
        r = r0;
        n = 0;
        while (r > 2) begin
            r = dadda_below(r);
            n++;
        end
        return n;
    endfunction

endpackage

// File: rtl/smfm_pp_gen.sv
`timescale 1ns/1ps
module smfm_pp_gen #(
    parameter int MAG_W = 31,
    parameter int ACC_W = 64
) (
    input  logic [MAG_W-1:0]             mag_a,
    input  logic [MAG_W-1:0]             mag_b,
    input  logic                         negate,
    output logic [MAG_W-1:0][ACC_W-1:0]  pp_rows,
    output logic [ACC_W-1:0]             fix_row
);

    // Inverting every row gives -x-1 per row; the fix row adds MAG_W back.
    for (genvar i = 0; i < MAG_W; i++) begin : g_row
        assign pp_rows[i] = {ACC_W{negate}}
                          ^ (ACC_W'(mag_a & {MAG_W{mag_b[i]}}) << i);
    end

    assign fix_row = negate ? ACC_W'(MAG_W) : '0;

endmodule

// File: rtl/smfm_csa_tree.sv
`timescale 1ns/1ps
module smfm_csa_tree
    import smfm_pkg::*;
#(
    parameter int SUM_W = 64,
    parameter int NROWS = 33
) (
    input  logic [NROWS-1:0][SUM_W-1:0] rows_in,
    output logic [SUM_W-1:0]            row_s,
    output logic [SUM_W-1:0]            row_c
);

    localparam int LEVELS = tree_levels(NROWS);

    logic [SUM_W-1:0] lvl [LEVELS+1][NROWS];

    for (genvar j = 0; j < NROWS; j++) begin : g_in
        assign lvl[0][j] = rows_in[j];
    end

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        localparam int R  = rows_after(NROWS, l);
        localparam int T  = dadda_below(R);
        localparam int NC = R - T;

        // Only as many 3:2 compressors as needed to reach the next height.
        for (genvar g = 0; g < NC; g++) begin : g_csa
            assign lvl[l+1][2*g]   = lvl[l][3*g] ^ lvl[l][3*g+1] ^ lvl[l][3*g+2];
            assign lvl[l+1][2*g+1] = ((lvl[l][3*g]   & lvl[l][3*g+1])
                                   |  (lvl[l][3*g]   & lvl[l][3*g+2])
                                   |  (lvl[l][3*g+1] & lvl[l][3*g+2])) << 1;
        end
        for (genvar k = 3*NC; k < R; k++) begin : g_pass
            assign lvl[l+1][2*NC + k - 3*NC] = lvl[l][k];
        end
        for (genvar k = T; k < NROWS; k++) begin : g_zero
            assign lvl[l+1][k] = '0;
        end
    end

    assign row_s = lvl[LEVELS][0];
    assign row_c = lvl[LEVELS][1];

endmodule

// File: rtl/smfm_cla.sv
`timescale 1ns/1ps
module smfm_cla #(
    parameter int W   = 64,
    parameter int GRP = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] sum
);

    localparam int NG = W / GRP;

    logic [W-1:0] gen;
    logic [W-1:0] prp;

    assign gen = x & y;
    assign prp = x ^ y;

    always_comb begin
        logic t;
        logic run;
        logic [NG-1:0] g_gen;
        logic [NG-1:0] g_prp;
        logic [NG-1:0] g_cin;

        // Group generate and propagate.
        for (int k = 0; k < NG; k++) begin
            t   = 1'b0;
            run = 1'b1;
            for (int j = GRP - 1; j >= 0; j--) begin
                t   = t | (run & gen[k*GRP+j]);
                run = run & prp[k*GRP+j];
            end
            g_gen[k] = t;
            g_prp[k] = run;
        end

        // Carry into each group, looked ahead over all lower groups.
        for (int k = 0; k < NG; k++) begin
            t   = 1'b0;
            run = 1'b1;
            for (int j = k - 1; j >= 0; j--) begin
                t   = t | (run & g_gen[j]);
                run = run & g_prp[j];
            end
            g_cin[k] = t;
        end

        // Bit carries inside each group from the group carry.
        for (int k = 0; k < NG; k++) begin
            for (int i = 0; i < GRP; i++) begin
                t   = 1'b0;
                run = 1'b1;
                for (int j = i - 1; j >= 0; j--) begin
                    t   = t | (run & gen[k*GRP+j]);
                    run = run & prp[k*GRP+j];
                end
                t = t | (run & g_cin[k]);
                sum[k*GRP+i] = prp[k*GRP+i] ^ t;
            end
        end
    end

endmodule

// File: rtl/smfm_mac_top.sv
`timescale 1ns/1ps
module smfm_mac_top
    import smfm_pkg::*;
#(
    parameter int OP_W  = 32,
    parameter int GRP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              acc_en,
    input  logic              acc_clr,
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    output logic [2*OP_W-1:0] acc_q,
    output logic              out_valid,
    output logic              ovf_sticky
);

    localparam int MAG_W = OP_W - 1;
    localparam int ACC_W = 2 * OP_W;
    localparam int NROWS = MAG_W + 2;

    mac_state_t state_q;
    mac_state_t state_d;

    logic                            fire;
    logic                            prod_neg;
    logic                            prod_nz;
    logic [MAG_W-1:0]                mag_a;
    logic [MAG_W-1:0]                mag_b;
    logic [MAG_W-1:0][ACC_W-1:0]     pp_rows;
    logic [ACC_W-1:0]                fix_row;
    logic [ACC_W-1:0]                acc_row;
    logic [NROWS-1:0][ACC_W-1:0]     all_rows;
    logic [ACC_W-1:0]                row_s;
    logic [ACC_W-1:0]                row_c;
    logic [ACC_W-1:0]                sum;
    logic                            ovf_step;

    assign fire     = in_valid & acc_en;
    assign mag_a    = op_a[MAG_W-1:0];
    assign mag_b    = op_b[MAG_W-1:0];
    assign prod_neg = op_a[OP_W-1] ^ op_b[OP_W-1];
    assign prod_nz  = (|mag_a) & (|mag_b);

    // The total joins the tree as a row; a clearing step feeds zero instead.
    assign acc_row  = acc_clr ? '0 : acc_q;
    assign all_rows = {fix_row, acc_row, pp_rows};

    smfm_pp_gen #(.MAG_W(MAG_W), .ACC_W(ACC_W)) u_pp (
        .mag_a   (mag_a),
        .mag_b   (mag_b),
        .negate  (prod_neg),
        .pp_rows (pp_rows),
        .fix_row (fix_row)
    );

    smfm_csa_tree #(.SUM_W(ACC_W), .NROWS(NROWS)) u_tree (
        .rows_in (all_rows),
        .row_s   (row_s),
        .row_c   (row_c)
    );

    smfm_cla #(.W(ACC_W), .GRP(GRP_W)) u_cla (
        .x   (row_s),
        .y   (row_c),
        .sum (sum)
    );

    assign ovf_step = !acc_clr && prod_nz
                   && (acc_q[ACC_W-1] == prod_neg)
                   && (sum[ACC_W-1] != acc_q[ACC_W-1]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY:   if (fire)             state_d = ST_LIVE;
            ST_LIVE:    if (fire && ovf_step) state_d = ST_WRAPPED;
            ST_WRAPPED: if (fire && acc_clr)  state_d = ST_LIVE;
            default:                          state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q     <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= fire;
            if (fire) acc_q <= sum;
        end
    end

    assign ovf_sticky = (state_q == ST_WRAPPED);

    a_r4_hold_total: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(acc_q));
    a_r4_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> !out_valid);
    a_r8_pulse_follows: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> out_valid);
    a_r5_zero_term: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !acc_clr && !prod_nz) |=> $stable(acc_q));
    a_r6_flag_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_sticky && !(fire && acc_clr)) |=> ovf_sticky);
    a_r3_flag_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && acc_clr) |=> !ovf_sticky);

endmodule

// File: tb/test_smfm_mac_top.sv
`timescale 1ns/1ps
module test_smfm_mac_top;

    localparam logic [31:0] NEG  = 32'h8000_0000;
    localparam logic [31:0] MAXP = 32'h7FFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        acc_en;
    logic        acc_clr;
    logic [31:0] op_a;
    logic [31:0] op_b;
    logic [63:0] acc_q;
    logic        out_valid;
    logic        ovf_sticky;

    always #2.5 clk = ~clk;

    smfm_mac_top i_smfm_mac_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .acc_en     (acc_en),
        .acc_clr    (acc_clr),
        .op_a       (op_a),
        .op_b       (op_b),
        .acc_q      (acc_q),
        .out_valid  (out_valid),
        .ovf_sticky (ovf_sticky)
    );

    typedef struct {
        logic        vld;
        logic [63:0] acc;
        logic        ovf;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    int          checks = 0;
    int          fails  = 0;
    logic [63:0] m_acc  = '0;
    logic        m_ovf  = 1'b0;

    task automatic push_step(input logic v, input logic en, input logic c,
                             input logic [31:0] a, input logic [31:0] b,
                             input string tag);
        logic [63:0] pm;
        logic [63:0] pv;
        logic [63:0] base;
        logic [63:0] res;
        logic        pneg;
        exp_t        e;
        @(negedge clk);
        in_valid = v;
        acc_en   = en;
        acc_clr  = c;
        op_a     = a;
        op_b     = b;
        if (v && en) begin
            pm   = {33'b0, a[30:0]} * {33'b0, b[30:0]};
            pneg = (a[31] ^ b[31]) && (pm != 0);
            pv   = pneg ? (64'd0 - pm) : pm;
            base = c ? 64'd0 : m_acc;
            res  = base + pv;
            if (c) m_ovf = 1'b0;
            else if (pm != 0 && base[63] == pv[63] && res[63] != base[63]) m_ovf = 1'b1;
            m_acc = res;
        end
        e.vld = v && en;
        e.acc = m_acc;
        e.ovf = m_ovf;
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // Monitor: compare one item per cycle, 1 ns after the capturing edge.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                checks++;
                if (out_valid !== e.vld || acc_q !== e.acc || ovf_sticky !== e.ovf) begin
                    fails++;
                    $display("FAIL %s: got valid=%0b acc=%h ovf=%0b, expected valid=%0b acc=%h ovf=%0b",
                             e.tag, out_valid, acc_q, ovf_sticky, e.vld, e.acc, e.ovf);
                end
            end
        end
    end

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog: run did not finish, got running expected finished");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; acc_en = 1'b0; acc_clr = 1'b0;
        op_a = '0; op_b = '0;
        repeat (4) @(negedge clk);
        checks++;
        if (acc_q !== 64'd0 || out_valid !== 1'b0 || ovf_sticky !== 1'b0) begin
            fails++;
            $display("FAIL R1 in reset: got acc=%h valid=%0b ovf=%0b, expected 0 0 0",
                     acc_q, out_valid, ovf_sticky);
        end
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        checks++;
        if (acc_q !== 64'd0 || out_valid !== 1'b0 || ovf_sticky !== 1'b0) begin
            fails++;
            $display("FAIL R1 after release: got acc=%h valid=%0b ovf=%0b, expected 0 0 0",
                     acc_q, out_valid, ovf_sticky);
        end

        push_step(1, 1, 1, 32'd3, 32'd5, "R3 clear loads product");
        push_step(1, 1, 0, NEG | 32'd2, 32'd4, "R2 R7 one negative operand");
        push_step(1, 1, 0, NEG | 32'd3, NEG | 32'd3, "R2 R7 both negative");
        push_step(1, 0, 1, 32'd100, 32'd100, "R4 enable low");
        push_step(0, 1, 1, 32'd100, 32'd100, "R4 valid low");
        push_step(1, 1, 0, NEG, 32'd5, "R5 negative zero operand a");
        push_step(1, 1, 0, 32'd5, NEG, "R5 negative zero operand b");
        push_step(1, 1, 0, 32'd1, NEG | 32'd20, "R2 total goes negative");
        push_step(1, 1, 0, NEG | 32'd7, 32'd1, "R2 negative plus negative");

        push_step(1, 1, 1, MAXP, MAXP, "R3 clear with max product");
        push_step(1, 1, 0, MAXP, MAXP, "R6 no overflow yet");
        push_step(1, 1, 0, MAXP, MAXP, "R6 positive overflow wraps");
        push_step(1, 1, 0, 32'd0, 32'd9, "R6 flag kept on zero step");
        push_step(1, 0, 1, MAXP, MAXP, "R6 flag kept on hold");
        push_step(1, 1, 0, 32'd2, NEG | 32'd3, "R6 flag kept on accumulate");
        push_step(1, 1, 1, 32'd2, 32'd2, "R3 clear drops flag");

        push_step(1, 1, 1, NEG | MAXP, MAXP, "R3 clear negative max");
        push_step(1, 1, 0, MAXP, NEG | MAXP, "R6 negative no overflow yet");
        push_step(1, 1, 0, NEG | MAXP, MAXP, "R6 negative overflow wraps");
        push_step(0, 0, 1, 32'd1, 32'd1, "R4 clear ignored when idle");

        for (int i = 0; i < 80; i++) begin
            push_step(($urandom % 8) != 0, ($urandom % 8) != 0, ($urandom % 10) == 0,
                      $urandom, $urandom, "R8 back-to-back stream");
        end
        for (int i = 0; i < 6; i++) begin
            push_step(1, 1, 0, $urandom % 1000, $urandom % 1000, "R8 consecutive steps");
        end
        push_step(0, 0, 0, 32'd0, 32'd0, "R4 final idle");

        repeat (3) @(negedge clk);
        checks++;
        if (sb_q.size() != 0) begin
            fails++;
            $display("FAIL R8 scoreboard drain: got %0d pending, expected 0", sb_q.size());
        end
        summary();
        $finish;
    end

endmodule